// File: doc/BRIEF.md
# Packet Timestamp Capture Registers

This block holds the system time at the moment a packet crosses its timing point, once for the transmit path and once for the receive path. Each direction has its own control register and a 64-bit captured time, read as two 32-bit words over a simple single-cycle register bus. The free-running 64-bit system time arrives as an input. The counter that produces it lives outside this block.

A transmit packet is stamped only when its per-packet request flag is high. Receive stamping is either off or applies to every packet, chosen by a type field. After a capture the direction locks. Further events are dropped until software reads the high word of the held value, and that read re-arms capture. On receive, the block raises a per-packet flag in the same cycle as a stamped event. The descriptor logic places this flag in status bit 0x100.

Top module: `pkt_stamp_regs`

## Requirements
- R1: After reset, both control registers read 0, all four captured-time words read 0, and `rx_taken` is 0.
- R2: The transmit control register at 0xB614 stores an enable in bit 4. Bit 0 is a read-only valid flag, and writes to bit 0 have no effect. All other bits read 0.
- R3: The receive control register at 0xB620 stores an enable in bit 4, a type field in bits 3:1 and a clock-configuration bit in bit 5. Bit 0 is a read-only valid flag. All other bits read 0.
- R4: A cycle with `tx_evt` and `tx_req` high, transmit enabled and the transmit valid flag clear latches all 64 bits of `sys_time`. From the next cycle the valid flag reads 1, the low word reads at 0xB618 and the high word at 0xB61C.
- R5: A transmit event with `tx_req` low, or one that arrives while transmit is disabled, captures nothing.
- R6: A cycle with `rx_evt` high, receive enabled, type field 3'b100 (control value 0x08 in bits 3:1) and the receive valid flag clear latches `sys_time`. From the next cycle the valid flag reads 1, the low word reads at 0xB624 and the high word at 0xB628.
- R7: With any other receive type value, receive events capture nothing.
- R8: `rx_taken` is high in exactly those cycles where a receive event is captured, and low in all other cycles.
- R9: While a direction's valid flag is set, its events are dropped. The held time does not change and `rx_taken` stays low.
- R10: A read of a direction's high word clears its valid flag on the next cycle. A read of the low word leaves the flag set.
- R11: Reads of addresses that are not mapped return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sys_time | input | 64 | Current system time |
| tx_evt | input | 1 | Transmit packet at its timing point |
| tx_req | input | 1 | Packet asks for a timestamp |
| rx_evt | input | 1 | Receive packet at its timing point |
| rx_taken | output | 1 | Receive event was stamped this cycle |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 16 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of `bus_rd` |

## Verification
The bench aims events at the locked state. A design that forgot the lock would overwrite the held time, and the read-back of that value would be wrong. It reads the low word on its own to catch a design that re-arms too early. It issues a high-word read and a new event in the same cycle to show the event is dropped, not captured. Receive type values other than the all-packets code are tried while enabled, to catch a decoder that tests only the enable bit. Transmit events without a request are sent to catch a design that stamps every packet.

// File: rtl/pkt_stamp_regs.sv
module pkt_stamp_regs #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int TW = 64,
  parameter logic [AW-1:0] TX_CTRL_A = 16'hB614,
  parameter logic [AW-1:0] RX_CTRL_A = 16'hB620
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] sys_time,
  input  logic          tx_evt,
  input  logic          tx_req,
  input  logic          rx_evt,
  output logic          rx_taken,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata
);
  localparam logic [AW-1:0] TX_LO_A = TX_CTRL_A + AW'(4);
  localparam logic [AW-1:0] TX_HI_A = TX_CTRL_A + AW'(8);
  localparam logic [AW-1:0] RX_LO_A = RX_CTRL_A + AW'(4);
  localparam logic [AW-1:0] RX_HI_A = RX_CTRL_A + AW'(8);
  localparam logic [2:0]    RX_ALL  = 3'b100;

  logic          tx_en, tx_valid, rx_en, rx_sclk, rx_valid;
  logic [2:0]    rx_type;
  logic [TW-1:0] tx_stamp, rx_stamp;
  logic          tx_cap, rx_cap, tx_hi_rd, rx_hi_rd;

  assign tx_cap   = tx_evt && tx_req && tx_en && !tx_valid;
  assign rx_cap   = rx_evt && rx_en && (rx_type == RX_ALL) && !rx_valid;
  assign tx_hi_rd = bus_rd && (bus_addr == TX_HI_A);
  assign rx_hi_rd = bus_rd && (bus_addr == RX_HI_A);
  assign rx_taken = rx_cap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_en    <= 1'b0;
      tx_valid <= 1'b0;
      tx_stamp <= '0;
      rx_en    <= 1'b0;
      rx_type  <= 3'b000;
      rx_sclk  <= 1'b0;
      rx_valid <= 1'b0;
      rx_stamp <= '0;
    end else begin
      if (bus_wr && bus_addr == TX_CTRL_A)
        tx_en <= bus_wdata[4];
      if (bus_wr && bus_addr == RX_CTRL_A) begin
        rx_en   <= bus_wdata[4];
        rx_type <= bus_wdata[3:1];
        rx_sclk <= bus_wdata[5];
      end
      if (tx_cap) begin
        tx_stamp <= sys_time;
        tx_valid <= 1'b1;
      end else if (tx_hi_rd) begin
        tx_valid <= 1'b0;
      end
      if (rx_cap) begin
        rx_stamp <= sys_time;
        rx_valid <= 1'b1;
      end else if (rx_hi_rd) begin
        rx_valid <= 1'b0;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      TX_CTRL_A: bus_rdata = DW'({tx_en, 3'b000, tx_valid});
      TX_LO_A:   bus_rdata = tx_stamp[DW-1:0];
      TX_HI_A:   bus_rdata = tx_stamp[TW-1:DW];
      RX_CTRL_A: bus_rdata = DW'({rx_sclk, rx_en, rx_type, rx_valid});
      RX_LO_A:   bus_rdata = rx_stamp[DW-1:0];
      RX_HI_A:   bus_rdata = rx_stamp[TW-1:DW];
      default:   bus_rdata = '0;
    endcase
  end
endmodule

module pkt_stamp_chk #(
  parameter int AW = 16,
  parameter int TW = 64,
  parameter logic [AW-1:0] TX_HI = 16'hB61C,
  parameter logic [AW-1:0] RX_HI = 16'hB628
) (
  input logic          clk,
  input logic          rst_n,
  input logic [TW-1:0] sys_time,
  input logic          tx_evt,
  input logic          tx_req,
  input logic          rx_evt,
  input logic          rx_taken,
  input logic          bus_rd,
  input logic [AW-1:0] bus_addr,
  input logic          tx_en,
  input logic          tx_valid,
  input logic          rx_valid,
  input logic [TW-1:0] tx_stamp,
  input logic [TW-1:0] rx_stamp
);
  // R4
  tx_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_evt && tx_req && tx_en && !tx_valid |=> tx_valid && tx_stamp == $past(sys_time));
  // R5
  tx_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_valid && !(tx_evt && tx_req) |=> !tx_valid);
  // R6
  rx_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_taken |=> rx_valid && rx_stamp == $past(sys_time));
  // R8
  rx_taken_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_taken |-> rx_evt && !rx_valid);
  // R9
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && $past(tx_valid) |-> $stable(tx_stamp));
  // R9
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && $past(rx_valid) |-> $stable(rx_stamp));
  // R10
  tx_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && bus_addr == TX_HI && tx_valid |=> !tx_valid);
  // R10
  rx_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && bus_addr == RX_HI && rx_valid |=> !rx_valid);
endmodule

bind pkt_stamp_regs pkt_stamp_chk #(.AW(AW), .TW(TW), .TX_HI(TX_HI_A), .RX_HI(RX_HI_A)) u_chk (
  .clk(clk), .rst_n(rst_n), .sys_time(sys_time), .tx_evt(tx_evt), .tx_req(tx_req),
  .rx_evt(rx_evt), .rx_taken(rx_taken), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .tx_en(tx_en), .tx_valid(tx_valid), .rx_valid(rx_valid),
  .tx_stamp(tx_stamp), .rx_stamp(rx_stamp)
);

// File: tb/test_pkt_stamp_regs.sv
module test_pkt_stamp_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] sys_time = 64'h0123_4567_89AB_CDEF;
  logic        tx_evt = 1'b0, tx_req = 1'b0, rx_evt = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_addr = 16'h0;
  logic [31:0] bus_wdata = 32'h0;
  logic        rx_taken;
  logic [31:0] bus_rdata;
  int checks = 0, fails = 0;

  // reference state
  logic        m_txen, m_txv, m_rxen, m_rxsc, m_rxv;
  logic [2:0]  m_rxty;
  logic [63:0] m_txs, m_rxs;

  always #2 clk = ~clk;

  pkt_stamp_regs i_pkt_stamp_regs (
    .clk(clk), .rst_n(rst_n), .sys_time(sys_time), .tx_evt(tx_evt), .tx_req(tx_req),
    .rx_evt(rx_evt), .rx_taken(rx_taken), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  function automatic logic m_rx_take();
    return rx_evt && m_rxen && m_rxty == 3'b100 && !m_rxv;
  endfunction

  function automatic logic [31:0] m_read(input logic [15:0] a);
    case (a)
      16'hB614: return {27'b0, m_txen, 3'b0, m_txv};
      16'hB618: return m_txs[31:0];
      16'hB61C: return m_txs[63:32];
      16'hB620: return {26'b0, m_rxsc, m_rxen, m_rxty, m_rxv};
      16'hB624: return m_rxs[31:0];
      16'hB628: return m_rxs[63:32];
      default:  return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [15:0] a);
    case (a)
      16'hB614: return "R2";
      16'hB618, 16'hB61C: return "R4";
      16'hB620: return "R3";
      16'hB624, 16'hB628: return "R6";
      default: return "R11";
    endcase
  endfunction

  always @(posedge clk) begin
    sys_time <= sys_time + 64'h0000_0003_1000_0007;
    if (!rst_n) begin
      m_txen <= 0; m_txv <= 0; m_rxen <= 0; m_rxsc <= 0; m_rxv <= 0;
      m_rxty <= 0; m_txs <= 0; m_rxs <= 0;
    end else begin
      if (bus_wr && bus_addr == 16'hB614) m_txen <= bus_wdata[4];
      if (bus_wr && bus_addr == 16'hB620) begin
        m_rxen <= bus_wdata[4]; m_rxty <= bus_wdata[3:1]; m_rxsc <= bus_wdata[5];
      end
      if (tx_evt && tx_req && m_txen && !m_txv) begin m_txs <= sys_time; m_txv <= 1; end
      else if (bus_rd && bus_addr == 16'hB61C) m_txv <= 0;
      if (m_rx_take()) begin m_rxs <= sys_time; m_rxv <= 1; end
      else if (bus_rd && bus_addr == 16'hB628) m_rxv <= 0;
    end
  end

  // compared on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (rx_taken !== m_rx_take()) begin
        fails++;
        $display("FAIL R8 rx_taken actual %0b expected %0b", rx_taken, m_rx_take());
      end
      if (bus_rd) begin
        checks++;
        if (bus_rdata !== m_read(bus_addr)) begin
          fails++;
          $display("FAIL %s read %h actual %h expected %h", tag_of(bus_addr), bus_addr,
                   bus_rdata, m_read(bus_addr));
        end
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d; step(); bus_wr = 0;
  endtask

  task automatic rd(input logic [15:0] a);
    bus_rd = 1; bus_addr = a; step(); bus_rd = 0;
  endtask

  task automatic poll();
    rd(16'hB614); rd(16'hB618); rd(16'hB620); rd(16'hB624);
    rd(16'hB610); rd(16'hB62C);
  endtask

  task automatic ev(input logic t, input logic q, input logic r);
    tx_evt = t; tx_req = q; rx_evt = r; step(); tx_evt = 0; tx_req = 0; rx_evt = 0;
  endtask

  initial begin
    #10000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_n = 1;
    poll();                               // R1 reset values
    wr(16'hB614, 32'hFFFF_FFFF); poll(); // R2 bit 0 and others ignored
    wr(16'hB620, 32'hFFFF_FFFF); poll(); // R3 type 111, sysclk kept
    ev(0, 0, 1); poll();                  // R7 wrong type, no stamp
    wr(16'hB620, 32'h0000_0014); ev(0, 0, 1); poll(); // R7 type 010
    ev(1, 0, 0); poll();                  // R5 no request
    ev(1, 1, 0); poll();                  // R4 capture
    ev(1, 1, 0); step(); ev(1, 1, 0); poll(); // R9 dropped while locked
    rd(16'hB618); rd(16'hB614);           // R10 low read keeps valid
    ev(1, 1, 0); rd(16'hB61C); poll();    // R10 high read clears
    ev(1, 1, 0); rd(16'hB61C); rd(16'hB618);   // R4 new capture
    wr(16'hB620, 32'h0000_0018);          // R6 all packets
    ev(0, 0, 1); poll();                  // R6 R8
    ev(0, 0, 1); ev(1, 1, 1); poll();     // R9 rx locked, tx captures
    bus_rd = 1; bus_addr = 16'hB628; rx_evt = 1; tx_evt = 1; tx_req = 1;
    step(); bus_rd = 0; rx_evt = 0; tx_evt = 0; tx_req = 0; // R9 event dropped at re-arm
    poll(); rd(16'hB628);
    rd(16'hB61C);
    wr(16'hB614, 32'h0); ev(1, 1, 0); poll(); rd(16'hB61C); // R5 disabled
    ev(0, 0, 1); rd(16'hB628);            // R6 re-armed capture
    wr(16'hB620, 32'h0000_0008); ev(0, 0, 1); poll(); // R7 enable clear
    rd(16'hB600); rd(16'hB630);           // R11
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule